// File: doc/BRIEF.md
# Wiper Position Register with Tap Decode

This block holds the 8-bit position of a digitally controlled potentiometer wiper and turns it into the enable pattern for the tap switches of the resistor string. The position is volatile. It can be set in four ways. The host can write a value directly. A stored setting can be copied in from one of the bank-zero data registers. The wiper can be nudged one tap up or down. The stored default can be recalled at power-up, or on request.

The surrounding logic supplies each source as a strobe paired with a data byte. The stored default setting arrives on its own byte input. One register-stage after any strobe, the block shows the new position and a 256-bit switch-enable vector. That vector drives exactly one tap, with bit 0 at the low terminal and bit 255 at the high terminal. The resistor array itself lies outside the block.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: While rstN is low, wiperPos reads 00h and tapSel has only bit 0 set.
- R2: At the first rising clock edge after rstN goes high, wiperPos takes the value of recallData. Later, a recallStb high at a rising edge does the same.
- R3: At every rising edge outside reset, tapSel has exactly one bit set.
- R4: The set bit of tapSel is the bit whose index equals wiperPos, so 00h selects bit 0 (low end) and FFh selects bit 255 (high end). Both outputs change on the same edge.
- R5: When xferStb is high at a rising edge, wiperPos takes xferData.
- R6: When loadStb is high at a rising edge, wiperPos takes loadData.
- R7: When stepUp alone is high, wiperPos rises by one at the edge. When stepDown alone is high, wiperPos falls by one.
- R8: A step up at FFh leaves the value at FFh, and a step down at 00h leaves it at 00h. The value never wraps.
- R9: When several sources act in one cycle, the winner is chosen in this order: recall (strobe or the pending power-up recall), then transfer, then direct load, then step.
- R10: When stepUp and stepDown are high together with no other source, the position does not change.
- R11: When no source is active, wiperPos and tapSel hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| recallStb | input | 1 | Recall the stored default position |
| recallData | input | 8 | Stored default position (bank-zero register 0) |
| xferStb | input | 1 | Copy a bank-zero data register into the wiper |
| xferData | input | 8 | Contents of the selected bank-zero register |
| loadStb | input | 1 | Direct host write of the wiper |
| loadData | input | 8 | Value written by the host |
| stepUp | input | 1 | Move one tap toward the high end |
| stepDown | input | 1 | Move one tap toward the low end |
| wiperPos | output | 8 | Current wiper position |
| tapSel | output | 256 | One-hot tap switch enables, bit n = position n |

## Verification
Every source takes effect at the first rising edge that sees its strobe, and wiperPos and tapSel appear together one register-stage later. The power-up recall happens at the first edge after reset is released. The bench changes inputs on the falling edge and samples at the next falling edge, exactly one rising edge later. At that point it compares both the position and the whole 256-bit vector against a one-hot pattern built from the expected position. Hold and cancellation cases are sampled one edge after the stimulus, before any other strobe is applied.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // One-hot selection of the update source chosen by the control
  typedef struct packed {
    logic recall;
    logic xfer;
    logic load;
    logic up;
    logic down;
  } wiperCmd_t;

endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      recallStb,
  input  logic      xferStb,
  input  logic      loadStb,
  input  logic      stepUp,
  input  logic      stepDown,
  output wiperCmd_t cmd
);

  // Power-up recall is owed once after reset release
  logic pendRecall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendRecall <= 1'b1;
    else       pendRecall <= 1'b0;
  end

  // Fixed priority: recall, transfer, direct load, step
  always_comb begin
    cmd = '0;
    if (recallStb || pendRecall) begin
      cmd.recall = 1'b1;
    end else if (xferStb) begin
      cmd.xfer = 1'b1;
    end else if (loadStb) begin
      cmd.load = 1'b1;
    end else if (stepUp ^ stepDown) begin
      cmd.up   = stepUp;
      cmd.down = stepDown;
    end
  end

endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  wiperCmd_t        cmd,
  input  logic [POS_W-1:0] recallData,
  input  logic [POS_W-1:0] xferData,
  input  logic [POS_W-1:0] loadData,
  output logic [POS_W-1:0] nextPos,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] TOP_POS = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] BOT_POS = '0;
  localparam logic [POS_W-1:0] ONE     = POS_W'(1);

  always_comb begin
    nextPos = pos;
    if (cmd.recall)                        nextPos = recallData;
    else if (cmd.xfer)                     nextPos = xferData;
    else if (cmd.load)                     nextPos = loadData;
    else if (cmd.up   && pos != TOP_POS)   nextPos = pos + ONE;
    else if (cmd.down && pos != BOT_POS)   nextPos = pos - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pos <= BOT_POS;
    else       pos <= nextPos;
  end

endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
  parameter int POS_W = 8,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] nextPos,
  output logic [TAPS-1:0]  tapQ
);

  logic [TAPS-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < TAPS; gi++) begin : gTap
      assign hit[gi] = (nextPos == POS_W'(gi));
    end
  endgenerate

  // Registered so the vector switches atomically from one tap to the next
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tapQ <= TAPS'(1);
    else       tapQ <= hit;
  end

endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl
  import wiper_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         recallStb,
  input  logic [7:0]   recallData,
  input  logic         xferStb,
  input  logic [7:0]   xferData,
  input  logic         loadStb,
  input  logic [7:0]   loadData,
  input  logic         stepUp,
  input  logic         stepDown,
  output logic [7:0]   wiperPos,
  output logic [255:0] tapSel
);

  localparam int POS_W = 8;

  wiperCmd_t        cmd;
  logic [POS_W-1:0] nextPos;

  wiper_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .recallStb(recallStb),
    .xferStb  (xferStb),
    .loadStb  (loadStb),
    .stepUp   (stepUp),
    .stepDown (stepDown),
    .cmd      (cmd)
  );

  wiper_datapath #(.POS_W(POS_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .recallData(recallData),
    .xferData  (xferData),
    .loadData  (loadData),
    .nextPos   (nextPos),
    .pos       (wiperPos)
  );

  tap_decoder #(.POS_W(POS_W)) u_dec (
    .clk    (clk),
    .rstN   (rstN),
    .nextPos(nextPos),
    .tapQ   (tapSel)
  );

endmodule

// File: rtl/wiper_tap_chk.sv
module wiper_tap_chk (
  input logic         clk,
  input logic         rstN,
  input logic         recallStb,
  input logic [7:0]   recallData,
  input logic         xferStb,
  input logic [7:0]   xferData,
  input logic         loadStb,
  input logic [7:0]   loadData,
  input logic         stepUp,
  input logic         stepDown,
  input logic [7:0]   wiperPos,
  input logic [255:0] tapSel
);

  // High from the second edge after reset release onward
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  logic quiet;
  assign quiet = !recallStb && !xferStb && !loadStb;

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSel) == 1); // R3

  AST_TAP_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    tapSel[wiperPos] == 1'b1); // R4

  AST_RECALL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    recallStb |=> wiperPos == $past(recallData)); // R2

  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !recallStb && xferStb) |=> wiperPos == $past(xferData)); // R5

  AST_HOST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !recallStb && !xferStb && loadStb) |=> wiperPos == $past(loadData)); // R6

  AST_TOP_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (armed && quiet && stepUp && !stepDown && wiperPos == 8'hFF) |=> wiperPos == 8'hFF); // R8

  AST_BOT_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (armed && quiet && stepDown && !stepUp && wiperPos == 8'h00) |=> wiperPos == 8'h00); // R8

  AST_STEP_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (armed && quiet && stepUp && stepDown) |=> $stable(wiperPos)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (armed && quiet && !stepUp && !stepDown) |=> ($stable(wiperPos) && $stable(tapSel))); // R11

endmodule

bind wiper_tap_ctrl wiper_tap_chk u_chk (.*);

// File: tb/tb_wiper_tap_ctrl.sv
module tb_wiper_tap_ctrl;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         recallStb = 1'b0;
  logic [7:0]   recallData = 8'h00;
  logic         xferStb = 1'b0;
  logic [7:0]   xferData = 8'h00;
  logic         loadStb = 1'b0;
  logic [7:0]   loadData = 8'h00;
  logic         stepUp = 1'b0;
  logic         stepDown = 1'b0;
  logic [7:0]   wiperPos;
  logic [255:0] tapSel;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wiper_tap_ctrl dut (
    .clk(clk), .rstN(rstN),
    .recallStb(recallStb), .recallData(recallData),
    .xferStb(xferStb), .xferData(xferData),
    .loadStb(loadStb), .loadData(loadData),
    .stepUp(stepUp), .stepDown(stepDown),
    .wiperPos(wiperPos), .tapSel(tapSel)
  );

  task automatic expectPos(input string tag, input logic [7:0] exp);
    logic [255:0] expVec;
    expVec = '0;
    expVec[exp] = 1'b1;
    checks++;
    if (wiperPos !== exp) begin
      fails++;
      $display("FAIL %s: wiperPos actual %h expected %h", tag, wiperPos, exp);
    end
    checks++;
    if (tapSel !== expVec) begin
      fails++;
      $display("FAIL %s: tapSel actual %h expected %h", tag, tapSel, expVec);
    end
  endtask

  // Drive strobes after a falling edge, hold across one rising edge, clear
  task automatic drive(input logic rs, input logic xs, input logic ls,
                       input logic up, input logic dn);
    recallStb = rs; xferStb = xs; loadStb = ls; stepUp = up; stepDown = dn;
    @(negedge clk);
    recallStb = 1'b0; xferStb = 1'b0; loadStb = 1'b0; stepUp = 1'b0; stepDown = 1'b0;
  endtask

  task automatic setTo(input logic [7:0] v);
    loadData = v;
    drive(0, 0, 1, 0, 0);
  endtask

  task automatic testReset();
    recallData = 8'h5A;
    @(negedge clk);
    expectPos("R1 reset state", 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    expectPos("R2 power-up recall", 8'h5A);
  endtask

  task automatic testSources();
    xferData = 8'hC3;
    drive(0, 1, 0, 0, 0);
    expectPos("R5 transfer", 8'hC3);
    loadData = 8'h17;
    drive(0, 0, 1, 0, 0);
    expectPos("R6 direct load", 8'h17);
    recallData = 8'hA0;
    drive(1, 0, 0, 0, 0);
    expectPos("R2 recall strobe", 8'hA0);
    loadData = 8'hFF;
    drive(0, 0, 1, 0, 0);
    expectPos("R4 high end tap", 8'hFF);
    loadData = 8'h00;
    drive(0, 0, 1, 0, 0);
    expectPos("R4 low end tap", 8'h00);
  endtask

  task automatic testSteps();
    setTo(8'h40);
    for (int i = 1; i <= 5; i++) begin
      drive(0, 0, 0, 1, 0);
      expectPos("R7 step up", 8'(8'h40 + i));
    end
    for (int i = 1; i <= 3; i++) begin
      drive(0, 0, 0, 0, 1);
      expectPos("R7 step down", 8'(8'h45 - i));
    end
    setTo(8'hFE);
    drive(0, 0, 0, 1, 0);
    expectPos("R7 step to top", 8'hFF);
    drive(0, 0, 0, 1, 0);
    expectPos("R8 saturate high", 8'hFF);
    setTo(8'h01);
    drive(0, 0, 0, 0, 1);
    expectPos("R7 step to bottom", 8'h00);
    drive(0, 0, 0, 0, 1);
    expectPos("R8 saturate low", 8'h00);
  endtask

  task automatic testPriority();
    setTo(8'h20);
    recallData = 8'h11; xferData = 8'h22; loadData = 8'h33;
    drive(1, 1, 1, 1, 0);
    expectPos("R9 recall wins", 8'h11);
    drive(0, 1, 1, 0, 1);
    expectPos("R9 transfer beats load", 8'h22);
    drive(0, 0, 1, 1, 0);
    expectPos("R9 load beats step", 8'h33);
    drive(1, 0, 0, 0, 1);
    expectPos("R9 recall beats step", 8'h11);
  endtask

  task automatic testHold();
    setTo(8'h80);
    drive(0, 0, 0, 1, 1);
    expectPos("R10 both steps cancel", 8'h80);
    recallData = 8'h01; xferData = 8'h02; loadData = 8'h03;
    drive(0, 0, 0, 0, 0);
    expectPos("R11 idle hold", 8'h80);
    @(negedge clk);
    expectPos("R11 idle hold later", 8'h80);
  endtask

  task automatic testMidReset();
    setTo(8'h99);
    recallData = 8'h3C;
    rstN = 1'b0;
    #1;
    expectPos("R1 async reset", 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectPos("R2 recall after reset", 8'h3C);
  endtask

  initial begin
    testReset();
    testSources();
    testSteps();
    testPriority();
    testHold();
    testMidReset();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule